// File: doc/BRIEF.md
# TMDS Double-Data-Rate Lane Serializer

This block turns three 10-bit encoded video symbols, presented once per pixel clock, into bit streams for double-data-rate output cells. The fast clock runs at five times the pixel clock and comes from the same PLL, so it keeps a fixed phase to the pixel clock. Each fast cycle hands one 2-bit pair to the output stage. The line therefore carries ten bits per pixel period on each lane. A fourth lane carries the pixel clock in the same format, as the constant symbol whose five low bits are zero and whose five high bits are one.

Each symbol is captured in the pixel domain, which then flips a toggle flag. Two flops synchronize that flag into the fast domain, and a detected change loads the symbol into a per-lane shift stage. After that, a pair counter walks the five pairs of the symbol. A behavioural double-data-rate stage registers both bits of a pair on the fast rising edge. It drives the rising bit while the fast clock is high and the falling bit while it is low.

Top module: `tmds_ddr_serializer`

## Requirements
- R1: Each data lane (lane 0 blue, lane 1 green, lane 2 red) transmits all ten bits of one symbol per pixel period, and every symbol is recovered unchanged and in order.
- R2: Each lane emits exactly five 2-bit pairs per pixel period, one pair per fast clock cycle.
- R3: Bit 0 of a symbol goes out first. In each pair the even-indexed bit is the rising-half bit and the odd-indexed bit is the falling-half bit.
- R4: Once the first symbol has been loaded, loads occur exactly every five fast cycles, each load lasts one fast cycle, and a load coincides with the cycle in which the last pair of the previous symbol is being sent.
- R5: Lane 3 carries the constant symbol 10'b1111100000 (bits 0 to 4 low, bits 5 to 9 high). Its frame boundaries recur every five fast cycles.
- R6: Bit 0 of a symbol captured at a pixel rising edge is driven after the fourth fast rising edge that follows that pixel edge. Bit 9 is driven after the eighth.
- R7: While reset is active all lanes, rising bits and falling bits are low. No frame appears before the first pixel edge after reset.
- R8: tx_line equals ddr_rise while clk_fast is high and ddr_fall while clk_fast is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel clock |
| clk_fast | input | 1 | Serializer clock, 5x pixel clock, phase-locked |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| sym_blue | input | 10 | Encoded symbol for lane 0 |
| sym_green | input | 10 | Encoded symbol for lane 1 |
| sym_red | input | 10 | Encoded symbol for lane 2 |
| ddr_rise | output | 4 | Per-lane bit presented for the rising half |
| ddr_fall | output | 4 | Per-lane bit presented for the falling half |
| tx_line | output | 4 | Modelled DDR output line per lane (lane 3 is the clock) |

## Verification
Two things happen on the same fast edge: the load of a new symbol into the shift stage, and the transfer of the last pair of the previous symbol into the output registers. The bench provokes this on every pixel period. It drives back-to-back symbols that differ in every bit (all ones after all zeros, alternating patterns, walking ones) and random words. It then deserializes all four lines at mid-half sampling points. Any slip at that edge shows as a damaged symbol on a data lane, as a clock-lane frame that does not come exactly five cycles after the previous one, or as a wrong capture-to-output latency.

// File: rtl/tmds_ser_pkg.sv
package tmds_ser_pkg;

  localparam int unsigned DDR_W = 2;

  // Pair idx of a word: {odd bit, even bit}; the even bit leaves on the rising half.
  function automatic logic [DDR_W-1:0] pick_pair(input logic [31:0] word,
                                                 input int unsigned idx);
    logic [DDR_W-1:0] p;
    p[0] = word[DDR_W*idx];
    p[1] = word[DDR_W*idx+1];
    return p;
  endfunction

  // Clock-lane word: lower half zeros, upper half ones (50% duty per pixel period).
  function automatic logic [31:0] clock_word(input int unsigned sym_w);
    logic [31:0] w;
    w = '0;
    for (int unsigned b = 0; b < 32; b++) begin
      if (b >= sym_w / 2 && b < sym_w) w[b] = 1'b1;
    end
    return w;
  endfunction

endpackage

// File: rtl/tmds_pix_capture.sv
module tmds_pix_capture #(
  parameter int unsigned SYM_W = 10,
  parameter int unsigned NDATA = 3,
  localparam int unsigned BUS_W = SYM_W * NDATA
) (
  input  logic             clk_pix,
  input  logic             rst_n,
  input  logic [BUS_W-1:0] din,
  output logic [BUS_W-1:0] hold,
  output logic             tgl
);

  // Holding register stays stable for a full pixel period, which covers the
  // fast-side sampling window opened by the toggle below.
  always_ff @(posedge clk_pix or negedge rst_n) begin
    if (!rst_n) begin
      hold <= '0;
      tgl  <= 1'b0;
    end else begin
      hold <= din;
      tgl  <= ~tgl;
    end
  end

endmodule

// File: rtl/tmds_fast_sync.sv
module tmds_fast_sync #(
  parameter int unsigned NPAIRS = 5,
  localparam int unsigned PH_W = (NPAIRS > 1) ? $clog2(NPAIRS) : 1,
  localparam logic [PH_W-1:0] LAST = PH_W'(NPAIRS - 1)
) (
  input  logic            clk_fast,
  input  logic            rst_n,
  input  logic            tgl_pix,
  output logic            load,
  output logic            locked,
  output logic [PH_W-1:0] ph
);

  logic s1_q, s2_q, s3_q;
  logic [PH_W-1:0] gap_q;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
      s3_q <= 1'b0;
    end else begin
      s1_q <= tgl_pix;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  // Any change of the synchronized toggle marks a fresh symbol.
  assign load = s2_q ^ s3_q;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
      ph     <= '0;
    end else begin
      if (load) locked <= 1'b1;
      if (load || ph == LAST) ph <= '0;
      else                    ph <= ph + 1'b1;
    end
  end

  // Saturating distance since the last load, used only by the checks.
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)                   gap_q <= '0;
    else if (load)                gap_q <= '0;
    else if (gap_q != {PH_W{1'b1}}) gap_q <= gap_q + 1'b1;
  end

  // R4: a load lands exactly when the pair counter reaches its last pair
  a_r4_load_on_last_pair: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (locked && load) |-> (ph == LAST));

  // R4: a load lasts a single fast cycle
  a_r4_single_cycle_load: assert property (@(posedge clk_fast) disable iff (!rst_n)
    load |=> !load);

  // R2: after lock no more than NPAIRS cycles pass without a load
  a_r2_no_missed_load: assert property (@(posedge clk_fast) disable iff (!rst_n)
    locked |-> (gap_q <= LAST));

endmodule

// File: rtl/tmds_lane_ser.sv
module tmds_lane_ser
  import tmds_ser_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned NPAIRS = SYM_W / DDR_W,
  localparam int unsigned PH_W = (NPAIRS > 1) ? $clog2(NPAIRS) : 1
) (
  input  logic             clk_fast,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PH_W-1:0]  ph,
  input  logic [SYM_W-1:0] word,
  output logic             rise_q,
  output logic             fall_q
);

  logic [SYM_W-1:0] sh_q;
  logic [DDR_W-1:0] pair;

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n)    sh_q <= '0;
    else if (load) sh_q <= word;
  end

  always_comb pair = pick_pair(32'(sh_q), int'(ph));

  // Output-cell model: both halves registered on the rising edge.
  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      rise_q <= pair[0];
      fall_q <= pair[1];
    end
  end

endmodule

// File: rtl/tmds_ddr_serializer.sv
module tmds_ddr_serializer
  import tmds_ser_pkg::*;
#(
  parameter int unsigned SYM_W = 10,
  localparam int unsigned NDATA  = 3,
  localparam int unsigned NLANES = NDATA + 1,
  localparam int unsigned NPAIRS = SYM_W / DDR_W,
  localparam int unsigned PH_W   = (NPAIRS > 1) ? $clog2(NPAIRS) : 1,
  localparam int unsigned CLK_LN = NLANES - 1
) (
  input  logic              clk_pix,
  input  logic              clk_fast,
  input  logic              rst_n,
  input  logic [SYM_W-1:0]  sym_blue,
  input  logic [SYM_W-1:0]  sym_green,
  input  logic [SYM_W-1:0]  sym_red,
  output logic [NLANES-1:0] ddr_rise,
  output logic [NLANES-1:0] ddr_fall,
  output logic [NLANES-1:0] tx_line
);

  localparam logic [31:0] CLK_WORD = clock_word(SYM_W);

  logic [SYM_W*NDATA-1:0] hold;
  logic                   tgl;
  logic                   load;
  logic                   locked;
  logic [PH_W-1:0]        ph;

  tmds_pix_capture #(.SYM_W(SYM_W), .NDATA(NDATA)) u_cap (
    .clk_pix (clk_pix),
    .rst_n   (rst_n),
    .din     ({sym_red, sym_green, sym_blue}),
    .hold    (hold),
    .tgl     (tgl)
  );

  tmds_fast_sync #(.NPAIRS(NPAIRS)) u_sync (
    .clk_fast (clk_fast),
    .rst_n    (rst_n),
    .tgl_pix  (tgl),
    .load     (load),
    .locked   (locked),
    .ph       (ph)
  );

  for (genvar ln = 0; ln < NLANES; ln++) begin : g_lane
    logic [SYM_W-1:0] lane_word;
    if (ln < NDATA) begin : g_data
      assign lane_word = hold[ln*SYM_W +: SYM_W];
    end else begin : g_clk
      assign lane_word = CLK_WORD[SYM_W-1:0];
    end
    tmds_lane_ser #(.SYM_W(SYM_W)) u_ser (
      .clk_fast (clk_fast),
      .rst_n    (rst_n),
      .load     (load),
      .ph       (ph),
      .word     (lane_word),
      .rise_q   (ddr_rise[ln]),
      .fall_q   (ddr_fall[ln])
    );
  end

  // Behavioural DDR output: rising bit in the high half, falling bit in the low half.
  assign tx_line = clk_fast ? ddr_rise : ddr_fall;

  // R5: after lock, the clock lane presents pair (ph-1) of its constant word
  a_r5_clock_lane_frame: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (locked && ph != '0) |->
      (ddr_rise[CLK_LN] == CLK_WORD[DDR_W*(int'(ph)-1)] &&
       ddr_fall[CLK_LN] == CLK_WORD[DDR_W*(int'(ph)-1)+1]));

  // R7: nothing leaves the lanes before the first load
  a_r7_quiet_until_lock: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !locked |-> (ddr_rise == '0 && ddr_fall == '0));

endmodule

// File: tb/tb_tmds_ddr_serializer.sv
`timescale 1ns/1ps
module tb_tmds_ddr_serializer;

  localparam int SYM_W = 10;
  localparam int NSYM  = 80;
  localparam logic [9:0] CLKW = 10'b1111100000;

  logic clk_fast = 1'b0;
  logic clk_pix  = 1'b0;
  logic rst_n    = 1'b0;
  logic [9:0] sym_blue = '0, sym_green = '0, sym_red = '0;
  logic [3:0] ddr_rise, ddr_fall, tx_line;

  int n_checks = 0;
  int n_fail   = 0;
  int fast_cnt = 0;
  int n_recov  = 0;
  bit finished = 1'b0;

  logic [29:0] exp_q[$];
  int          stamp_q[$];

  tmds_ddr_serializer #(.SYM_W(SYM_W)) dut (
    .clk_pix(clk_pix), .clk_fast(clk_fast), .rst_n(rst_n),
    .sym_blue(sym_blue), .sym_green(sym_green), .sym_red(sym_red),
    .ddr_rise(ddr_rise), .ddr_fall(ddr_fall), .tx_line(tx_line)
  );

  // 50 MHz fast clock; pixel clock at one fifth, trailing by 5 ns.
  initial forever #10 clk_fast = ~clk_fast;
  initial begin
    #15;
    forever begin clk_pix = 1'b1; #50; clk_pix = 1'b0; #50; end
  end
  always @(posedge clk_fast) fast_cnt <= fast_cnt + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [9:0] directed(input int i, input int lane);
    logic [9:0] v;
    case (i)
      0: v = 10'h000;  1: v = 10'h3FF;  2: v = 10'h155;  3: v = 10'h2AA;
      4: v = 10'h3FF;  5: v = 10'h000;  6: v = 10'h001;  default: v = 10'h200;
    endcase
    return (lane == 1) ? ~v : (lane == 2) ? {v[4:0], v[9:5]} : v;
  endfunction

  // Pixel-side driver: record what the DUT captures at each edge, then change.
  initial begin
    int idx = 0;
    void'($urandom(32'd20240611));
    sym_blue = directed(0, 0); sym_green = directed(0, 1); sym_red = directed(0, 2);
    forever begin
      @(posedge clk_pix);
      if (rst_n) begin
        exp_q.push_back({sym_red, sym_green, sym_blue});
        stamp_q.push_back(fast_cnt);
        idx++;
        #20;
        if (idx < 8) begin
          sym_blue = directed(idx, 0); sym_green = directed(idx, 1); sym_red = directed(idx, 2);
        end else begin
          sym_blue = 10'($urandom); sym_green = 10'($urandom); sym_red = 10'($urandom);
        end
      end
    end
  end

  // Deserializer on the modelled lines.
  initial begin
    logic [9:0] win [4];
    logic [3:0] r, f;
    int last_b = -1;
    for (int l = 0; l < 4; l++) win[l] = '0;
    forever begin
      @(posedge clk_fast);
      #5;
      r = tx_line;
      check(r == ddr_rise, "R8 high half", 32'(r), 32'(ddr_rise));
      #10;
      f = tx_line;
      check(f == ddr_fall, "R8 low half", 32'(f), 32'(ddr_fall));
      for (int l = 0; l < 4; l++) begin
        win[l] = {r[l], win[l][9:1]};
        win[l] = {f[l], win[l][9:1]};
      end
      if (rst_n && win[3] == CLKW) begin
        if (last_b >= 0)
          check(fast_cnt - last_b == 5, "R2 R4 R5 frame spacing",
                32'(fast_cnt - last_b), 32'd5);
        last_b = fast_cnt;
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 frame without captured symbol", 32'd1, 32'd0);
        end else begin
          logic [29:0] e;
          int st;
          e  = exp_q.pop_front();
          st = stamp_q.pop_front();
          for (int l = 0; l < 3; l++)
            check(win[l] == e[l*10 +: 10], "R1 R3 data lane symbol",
                  32'(win[l]), 32'(e[l*10 +: 10]));
          check(fast_cnt - st == 8, "R6 capture-to-line latency",
                32'(fast_cnt - st), 32'd8);
          n_recov++;
        end
      end
    end
  end

  // Reset behaviour, then run until all symbols are recovered.
  initial begin
    #100;
    check(tx_line == 4'h0 && ddr_rise == 4'h0 && ddr_fall == 4'h0,
          "R7 lanes low in reset", 32'({tx_line, ddr_rise, ddr_fall}), 32'd0);
    #150;
    check(tx_line == 4'h0 && ddr_rise == 4'h0 && ddr_fall == 4'h0,
          "R7 lanes low in reset", 32'({tx_line, ddr_rise, ddr_fall}), 32'd0);
    #52 rst_n = 1'b1;
    // Before the first captured symbol reaches the line, all lanes stay low.
    #60;
    check(ddr_rise == 4'h0 && ddr_fall == 4'h0, "R7 quiet before first symbol",
          32'({ddr_rise, ddr_fall}), 32'd0);
    wait (n_recov >= NSYM);
    check(n_recov >= NSYM, "R1 symbol count", 32'(n_recov), 32'(NSYM));
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  // Watchdog.
  initial begin
    #400000;
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog: actual %0d symbols expected %0d", n_recov, NSYM);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule